// File: doc/BRIEF.md
# Four-Point Integer Transform Butterfly

This block computes a one-dimensional forward integer transform of four signed samples. The four results are the weighted sums given by the weight rows (1,1,1,1), (2,1,-1,-2), (1,-1,-1,1) and (1,-2,2,-1). Contains no multiplier. A first adder layer forms two sums and two differences of input pairs: s03 = X0+X3, d03 = X0-X3, s12 = X1+X2 and d12 = X1-X2. A second layer combines these four terms into the outputs. Weights of magnitude two are single left shifts. The network therefore needs eight add/subtract operations and two shifts, where row-by-row evaluation would need twelve and four.

Samples arrive on a valid/ready stream. Each accepted vector is registered once and leaves one clock later on a second valid/ready stream. A vector transfers on a rising edge where valid and ready are both high. A source must hold its valid and data stable until the transfer. The block takes a new vector when its output register is empty, or in the same cycle in which the sink takes the current result. Back-pressure from the sink reaches the source in the same cycle.

Inputs are IN_W-bit two's complement values. The internal sums are IN_W+1 bits wide and the outputs are IN_W+3 bits wide, so no input combination can overflow.

Top module: `xform4_butterfly`

## Requirements
- R1: For an accepted vector, y0 equals X0 + X1 + X2 + X3 as a signed IN_W+3-bit value.
- R2: For an accepted vector, y1 equals 2·X0 + X1 − X2 − 2·X3.
- R3: For an accepted vector, y2 equals X0 − X1 − X2 + X3.
- R4: For an accepted vector, y3 equals X0 − 2·X1 + 2·X2 − X3.
- R5: All four results are exact when every input is the most positive value (2^(IN_W-1)−1) or the most negative value (−2^(IN_W-1)), in any mix.
- R6: After a vector is accepted on an edge (in_valid and in_ready high), out_valid is high from that edge on, and the results follow the order in which the vectors were accepted.
- R7: While out_valid is high and out_ready is low, in_ready is low, and out_valid and all four results stay unchanged on the next edge.
- R8: in_ready is high whenever out_valid is low or out_ready is high.
- R9: While rst_n is low, out_valid and all four results are zero.
- R10: If a result is taken (out_valid and out_ready high) and no new vector is accepted on that edge, out_valid is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take an input vector |
| x0 | input | IN_W | Sample 0, two's complement |
| x1 | input | IN_W | Sample 1, two's complement |
| x2 | input | IN_W | Sample 2, two's complement |
| x3 | input | IN_W | Sample 3, two's complement |
| out_valid | output | 1 | Result vector present |
| out_ready | input | 1 | Sink takes the result vector |
| y0 | output | IN_W+3 | Coefficient 0 |
| y1 | output | IN_W+3 | Coefficient 1 |
| y2 | output | IN_W+3 | Coefficient 2 |
| y3 | output | IN_W+3 | Coefficient 3 |

## Verification
The four results of a vector accepted on one edge are due on the output pins after that edge. They must stay there until the first edge on which out_ready is high. The bench drives inputs on the falling edge and samples every output five nanoseconds before the next rising edge. From those samples it decides which transfers that rising edge will perform, so an accept in one cycle is matched against the outputs in the next sampled cycle. When a result transfers, it is compared with a queue of products computed by direct multiplication. Stall and drain cycles are checked one cycle later against the values recorded in the previous sample.

// File: rtl/xform4_pkg.sv
package xform4_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_op_e;

  // Word growth: one bit per adder layer, one more for the doubled term
  function automatic int sum_width(input int in_w);
    return in_w + 1;
  endfunction

  function automatic int coef_width(input int in_w);
    return in_w + 3;
  endfunction

endpackage

// File: rtl/xform4_addsub.sv
module xform4_addsub
  import xform4_pkg::*;
#(
  parameter int         A_W     = 16,
  parameter int         B_W     = 16,
  parameter int         B_SHIFT = 0,
  parameter int         R_W     = 17,
  parameter addsub_op_e OP      = OP_ADD
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [R_W-1:0] r
);

  localparam int AEXT = R_W - A_W;
  localparam int BEXT = R_W - B_W;

  logic signed [R_W-1:0] a_x;
  logic signed [R_W-1:0] b_e;
  logic signed [R_W-1:0] b_x;

  assign a_x = {{AEXT{a[A_W-1]}}, a};
  assign b_e = {{BEXT{b[B_W-1]}}, b};
  assign b_x = b_e <<< B_SHIFT;

  generate
    if (OP == OP_SUB) begin : g_sub
      assign r = a_x - b_x;
    end else begin : g_add
      assign r = a_x + b_x;
    end
  endgenerate

endmodule

// File: rtl/xform4_prefold.sv
module xform4_prefold
  import xform4_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int S_W  = 17
) (
  input  logic [IN_W-1:0] x0,
  input  logic [IN_W-1:0] x1,
  input  logic [IN_W-1:0] x2,
  input  logic [IN_W-1:0] x3,
  output logic [S_W-1:0]  s03,
  output logic [S_W-1:0]  d03,
  output logic [S_W-1:0]  s12,
  output logic [S_W-1:0]  d12
);

  // Outer pair
  xform4_addsub #(.A_W(IN_W), .B_W(IN_W), .B_SHIFT(0), .R_W(S_W), .OP(OP_ADD))
    u_s03 (.a(x0), .b(x3), .r(s03));
  xform4_addsub #(.A_W(IN_W), .B_W(IN_W), .B_SHIFT(0), .R_W(S_W), .OP(OP_SUB))
    u_d03 (.a(x0), .b(x3), .r(d03));

  // Inner pair
  xform4_addsub #(.A_W(IN_W), .B_W(IN_W), .B_SHIFT(0), .R_W(S_W), .OP(OP_ADD))
    u_s12 (.a(x1), .b(x2), .r(s12));
  xform4_addsub #(.A_W(IN_W), .B_W(IN_W), .B_SHIFT(0), .R_W(S_W), .OP(OP_SUB))
    u_d12 (.a(x1), .b(x2), .r(d12));

endmodule

// File: rtl/xform4_combine.sv
module xform4_combine
  import xform4_pkg::*;
#(
  parameter int S_W = 17,
  parameter int C_W = 19
) (
  input  logic [S_W-1:0] s03,
  input  logic [S_W-1:0] d03,
  input  logic [S_W-1:0] s12,
  input  logic [S_W-1:0] d12,
  output logic [C_W-1:0] c0,
  output logic [C_W-1:0] c1,
  output logic [C_W-1:0] c2,
  output logic [C_W-1:0] c3
);

  // Even rows: sum and difference of the two pair sums
  xform4_addsub #(.A_W(S_W), .B_W(S_W), .B_SHIFT(0), .R_W(C_W), .OP(OP_ADD))
    u_c0 (.a(s03), .b(s12), .r(c0));
  xform4_addsub #(.A_W(S_W), .B_W(S_W), .B_SHIFT(0), .R_W(C_W), .OP(OP_SUB))
    u_c2 (.a(s03), .b(s12), .r(c2));

  // Odd rows: weight two is one left shift of the second operand
  xform4_addsub #(.A_W(S_W), .B_W(S_W), .B_SHIFT(1), .R_W(C_W), .OP(OP_ADD))
    u_c1 (.a(d12), .b(d03), .r(c1));
  xform4_addsub #(.A_W(S_W), .B_W(S_W), .B_SHIFT(1), .R_W(C_W), .OP(OP_SUB))
    u_c3 (.a(d03), .b(d12), .r(c3));

endmodule

// File: rtl/xform4_holdreg.sv
module xform4_holdreg #(
  parameter int W = 76
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

  assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/xform4_butterfly.sv
module xform4_butterfly
  import xform4_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] x0,
  input  logic [IN_W-1:0] x1,
  input  logic [IN_W-1:0] x2,
  input  logic [IN_W-1:0] x3,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [IN_W+2:0] y0,
  output logic [IN_W+2:0] y1,
  output logic [IN_W+2:0] y2,
  output logic [IN_W+2:0] y3
);

  localparam int S_W   = sum_width(IN_W);
  localparam int C_W   = coef_width(IN_W);
  localparam int PKT_W = 4 * C_W;

  logic [S_W-1:0]   s03, d03, s12, d12;
  logic [C_W-1:0]   c0, c1, c2, c3;
  logic [PKT_W-1:0] pkt_in, pkt_out;

  xform4_prefold #(.IN_W(IN_W), .S_W(S_W)) u_prefold (
    .x0(x0), .x1(x1), .x2(x2), .x3(x3),
    .s03(s03), .d03(d03), .s12(s12), .d12(d12)
  );

  xform4_combine #(.S_W(S_W), .C_W(C_W)) u_combine (
    .s03(s03), .d03(d03), .s12(s12), .d12(d12),
    .c0(c0), .c1(c1), .c2(c2), .c3(c3)
  );

  assign pkt_in = {c3, c2, c1, c0};

  xform4_holdreg #(.W(PKT_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pkt_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pkt_out)
  );

  assign y0 = pkt_out[0*C_W +: C_W];
  assign y1 = pkt_out[1*C_W +: C_W];
  assign y2 = pkt_out[2*C_W +: C_W];
  assign y3 = pkt_out[3*C_W +: C_W];

  // Direct weighted sums, for the checks only
  logic signed [C_W-1:0] xe0, xe1, xe2, xe3;
  logic signed [C_W-1:0] dir0, dir1, dir2, dir3;

  assign xe0 = {{(C_W-IN_W){x0[IN_W-1]}}, x0};
  assign xe1 = {{(C_W-IN_W){x1[IN_W-1]}}, x1};
  assign xe2 = {{(C_W-IN_W){x2[IN_W-1]}}, x2};
  assign xe3 = {{(C_W-IN_W){x3[IN_W-1]}}, x3};

  assign dir0 = xe0 + xe1 + xe2 + xe3;
  assign dir1 = 2 * xe0 + xe1 - xe2 - 2 * xe3;
  assign dir2 = xe0 - xe1 - xe2 + xe3;
  assign dir3 = xe0 - 2 * xe1 + 2 * xe2 - xe3;

  assert_row0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (y0 == $past(dir0)));

  assert_row1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (y1 == $past(dir1)));

  assert_row2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (y2 == $past(dir2)));

  assert_row3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (y3 == $past(dir3)));

  always_comb begin
    if (!rst_n) begin
      assert_reset_R9: assert (!out_valid && y0 == '0 && y1 == '0 && y2 == '0 && y3 == '0);
    end
  end

endmodule

// File: tb/xform4_butterfly_test.sv
`timescale 1ns/1ps
module xform4_butterfly_test;

  localparam int IN_W = 16;
  localparam int C_W  = IN_W + 3;
  localparam int MAXV = (1 << (IN_W - 1)) - 1;
  localparam int MINV = -(1 << (IN_W - 1));
  localparam int NCYC = 3000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [IN_W-1:0] x0 = '0, x1 = '0, x2 = '0, x3 = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [C_W-1:0]  y0, y1, y2, y3;

  always #10 clk = ~clk;

  xform4_butterfly #(.IN_W(IN_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .x0(x0), .x1(x1), .x2(x2), .x3(x3),
    .out_valid(out_valid), .out_ready(out_ready),
    .y0(y0), .y1(y1), .y2(y2), .y3(y3)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int q0[$], q1[$], q2[$], q3[$];
  bit qx[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sx(input logic [C_W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int pick(input int k);
    int r;
    r = int'($urandom % 4);
    if (r == 0) return MAXV;
    if (r == 1) return MINV;
    return int'($urandom % (1 << IN_W)) + MINV;
  endfunction

  // Corner vectors: every input at one of the two extremes
  function automatic int corner(input int v, input int lane);
    return ((v >> lane) & 1) ? MINV : MAXV;
  endfunction

  initial begin
    int  a0, a1, a2, a3;
    bit  pend;
    bit  was_stall, was_drain, was_acc;
    int  h0, h1, h2, h3;
    bit  ext;
    pend = 0; was_stall = 0; was_drain = 0; was_acc = 0;
    h0 = 0; h1 = 0; h2 = 0; h3 = 0;
    a0 = 0; a1 = 0; a2 = 0; a3 = 0;

    // R9: reset state
    @(posedge clk);
    @(negedge clk);
    #5;
    chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    chk(y0 == '0 && y1 == '0 && y2 == '0 && y3 == '0, "R9 results in reset", sx(y0) | sx(y1) | sx(y2) | sx(y3), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      if (!pend) begin
        if (c < 16) begin
          in_valid = 1'b1;
          a0 = corner(c, 0); a1 = corner(c, 1); a2 = corner(c, 2); a3 = corner(c, 3);
        end else if (c >= NCYC - 20) begin
          in_valid = 1'b0;
        end else begin
          in_valid = ($urandom % 4) != 0;
          a0 = pick(c); a1 = pick(c); a2 = pick(c); a3 = pick(c);
        end
        x0 = a0[IN_W-1:0]; x1 = a1[IN_W-1:0]; x2 = a2[IN_W-1:0]; x3 = a3[IN_W-1:0];
      end
      if (c < 16 || c >= NCYC - 20) out_ready = 1'b1;
      else if (c < 2000) out_ready = ($urandom % 3) != 0;
      else out_ready = ($urandom % 5) == 0;
      #5;

      // R8: ready rule
      if (!out_valid || out_ready)
        chk(in_ready == 1'b1, "R8 in_ready", int'(in_ready), 1);
      // R7: stall blocks input and holds output
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R7 in_ready during stall", int'(in_ready), 0);
      if (was_stall) begin
        chk(out_valid == 1'b1, "R7 out_valid held", int'(out_valid), 1);
        chk(sx(y0) == h0 && sx(y1) == h1 && sx(y2) == h2 && sx(y3) == h3,
            "R7 results held", sx(y0), h0);
      end
      if (was_drain)
        chk(out_valid == 1'b0, "R10 out_valid after drain", int'(out_valid), 0);
      if (was_acc)
        chk(out_valid == 1'b1, "R6 out_valid after accept", int'(out_valid), 1);

      // Transfer out on the coming edge
      if (out_valid && out_ready) begin
        chk(q0.size() != 0, "R6 result without accepted vector", q0.size(), 1);
        if (q0.size() != 0) begin
          int e0, e1, e2, e3;
          e0 = q0.pop_front(); e1 = q1.pop_front();
          e2 = q2.pop_front(); e3 = q3.pop_front();
          ext = qx.pop_front();
          chk(sx(y0) == e0, "R1 y0", sx(y0), e0);
          chk(sx(y1) == e1, "R2 y1", sx(y1), e1);
          chk(sx(y2) == e2, "R3 y2", sx(y2), e2);
          chk(sx(y3) == e3, "R4 y3", sx(y3), e3);
          if (ext)
            chk(sx(y0) == e0 && sx(y1) == e1 && sx(y2) == e2 && sx(y3) == e3,
                "R5 extreme inputs", sx(y1), e1);
        end
      end

      was_stall = out_valid && !out_ready;
      was_drain = out_valid && out_ready && !(in_valid && in_ready);
      was_acc   = in_valid && in_ready;
      h0 = sx(y0); h1 = sx(y1); h2 = sx(y2); h3 = sx(y3);

      // Transfer in on the coming edge: reference by direct products
      if (in_valid && in_ready) begin
        int v0, v1, v2, v3;
        v0 = int'($signed(x0)); v1 = int'($signed(x1));
        v2 = int'($signed(x2)); v3 = int'($signed(x3));
        q0.push_back( 1 * v0 + 1 * v1 + 1 * v2 + 1 * v3);
        q1.push_back( 2 * v0 + 1 * v1 - 1 * v2 - 2 * v3);
        q2.push_back( 1 * v0 - 1 * v1 - 1 * v2 + 1 * v3);
        q3.push_back( 1 * v0 - 2 * v1 + 2 * v2 - 1 * v3);
        qx.push_back((v0 == MAXV || v0 == MINV) && (v1 == MAXV || v1 == MINV) &&
                     (v2 == MAXV || v2 == MINV) && (v3 == MAXV || v3 == MINV));
      end
      pend = in_valid && !in_ready;
    end

    chk(q0.size() == 0, "R6 all accepted vectors delivered", q0.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule